// File: doc/BRIEF.md
# Paged Receive Ring Controller

This block decides where each byte of an incoming frame lands in a local buffer memory. The memory is split into 256-byte pages, and the page number forms the upper byte of a 16-bit buffer address. A window of pages, bounded by a programmable first page and a programmable end page, is used as a circular receive area. When writing reaches the end page, it continues at the first page of the window, so one frame can run across the wrap point.

The block accepts a byte stream with start-of-frame, end-of-frame and error markers. For every accepted byte it drives a buffer-memory write strobe, an address and the data. Each frame starts on a fresh page, given by a current-page register. At the end of a good frame, that register moves to the page after the frame's last page. The host marks the oldest unread page with a boundary register. A frame that would need the boundary page is dropped and flagged as an overflow. A frame that ends with the error marker is also dropped. A dropped frame leaves the current page where it was, so its pages can be reused.

The window registers can be changed only while the block is stopped. The boundary register can be written at any time.

Top module: `rx_ring_ctrl`

## Requirements
- R1: After reset, the first window page reads 0x40, the end page 0x80, and the current and boundary pages 0x40. There is no memory write and no status pulse.
- R2: A host write takes effect on the next cycle. The select code picks the register: 0 for the first window page, 1 for the end page, 2 for the boundary, 3 for the current page. Writes with codes 0, 1 and 3 are ignored while `run` is high. Code 2 is accepted in any state.
- R3: The first byte of a frame (`rx_sof` with `rx_valid`) is written at address {current page, 0x00}. Each following byte of the frame is written at the next address, with the byte value on `mem_wdata`.
- R4: After a byte at offset 0xFF, the next byte goes to offset 0x00 of the following page. If that page equals the end page, the next byte goes to offset 0x00 of the first window page, so a frame can run across the wrap.
- R5: An end byte without error commits the frame. `frame_ok` pulses for one cycle, one cycle after the end byte, and the current page becomes the page after the frame's last page, with the wrap applied.
- R6: An end byte with `rx_err` high drops the frame. `frame_bad` pulses one cycle later, `frame_ok` and `ring_ovf` stay low, and the current page does not change.
- R7: The page after the frame's present page is needed when a byte is written at offset 0xFF or when the end byte is written. If that page equals the boundary, `ring_ovf` and `frame_bad` pulse one cycle later and the current page does not change. Later bytes of the frame, up to and including its end byte, are not written.
- R8: While `run` is low, no byte is written. Outside a frame, bytes without `rx_sof` are not written.
- R9: A start marker that arrives inside a frame abandons that frame and restarts at {current page, 0x00}.
- R10: If `run` falls during a frame, the frame is abandoned without a commit or a pulse. Bytes after `run` rises again are not written until the next start marker.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | High while the block is receiving |
| cfg_we | input | 1 | Host register write strobe |
| cfg_sel | input | 2 | Register select: 0 first page, 1 end page, 2 boundary, 3 current page |
| cfg_wdata | input | 8 | Host write data |
| rx_valid | input | 1 | Receive byte valid |
| rx_sof | input | 1 | Byte is the first of a frame |
| rx_eof | input | 1 | Byte is the last of a frame |
| rx_err | input | 1 | Frame ends with an error (qualified by rx_eof) |
| rx_data | input | 8 | Receive byte |
| mem_we | output | 1 | Buffer memory write strobe |
| mem_addr | output | 16 | Buffer memory byte address |
| mem_wdata | output | 8 | Buffer memory write data |
| ring_start | output | 8 | First window page |
| ring_stop | output | 8 | End page (not used for data) |
| cur_page | output | 8 | Page where the next frame begins |
| bnd_page | output | 8 | Oldest unread page (host owned) |
| frame_ok | output | 1 | Pulse: frame committed |
| frame_bad | output | 1 | Pulse: frame dropped |
| ring_ovf | output | 1 | Pulse: frame dropped on overflow |

## Verification
A wrong write pointer shows up on `mem_addr` on the very next accepted byte. A page-crossing or wrap fault shows at the byte after offset 0xFF. A wrong commit decision shows one cycle after the end byte, in two places: the status pulses, and the `cur_page` output. That output then also sets the address of the next frame's first byte. A wrongly armed overflow or drop state either lets bytes through that should be suppressed, or suppresses good bytes, and this is visible at the write strobe within the same frame.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  typedef enum logic [1:0] {
    SEL_START = 2'd0,
    SEL_STOP  = 2'd1,
    SEL_BND   = 2'd2,
    SEL_CUR   = 2'd3
  } cfg_sel_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RECV = 2'd1,
    ST_DROP = 2'd2
  } rx_state_e;
endpackage

// File: rtl/rxr_page_step.sv
// Next page in the circular window: page + 1, replaced by the first page
// when the increment lands on the end page.
module rxr_page_step #(
  parameter int PAGE_W = 8
) (
  input  logic [PAGE_W-1:0] page,
  input  logic [PAGE_W-1:0] start_pg,
  input  logic [PAGE_W-1:0] stop_pg,
  output logic [PAGE_W-1:0] next_pg
);
  logic [PAGE_W-1:0] inc;

  always_comb begin
    inc     = page + 1'b1;
    next_pg = (inc == stop_pg) ? start_pg : inc;
  end
endmodule

// File: rtl/rxr_cfg_regs.sv
module rxr_cfg_regs
  import rxr_pkg::*;
#(
  parameter int          PAGE_W    = 8,
  parameter logic [7:0]  RST_START = 8'h40,
  parameter logic [7:0]  RST_STOP  = 8'h80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [PAGE_W-1:0] cfg_wdata,
  input  logic              commit,
  input  logic [PAGE_W-1:0] commit_page,
  output logic [PAGE_W-1:0] start_pg,
  output logic [PAGE_W-1:0] stop_pg,
  output logic [PAGE_W-1:0] bnd_pg,
  output logic [PAGE_W-1:0] cur_pg
);
  logic [PAGE_W-1:0] start_q, start_d;
  logic [PAGE_W-1:0] stop_q,  stop_d;
  logic [PAGE_W-1:0] bnd_q,   bnd_d;
  logic [PAGE_W-1:0] cur_q,   cur_d;
  logic              win_we;

  always_comb begin
    win_we  = cfg_we && !run;
    start_d = start_q;
    stop_d  = stop_q;
    bnd_d   = bnd_q;
    cur_d   = cur_q;
    if (win_we && cfg_sel == SEL_START) start_d = cfg_wdata;
    if (win_we && cfg_sel == SEL_STOP)  stop_d  = cfg_wdata;
    if (win_we && cfg_sel == SEL_CUR)   cur_d   = cfg_wdata;
    if (cfg_we && cfg_sel == SEL_BND)   bnd_d   = cfg_wdata;
    if (commit)                         cur_d   = commit_page;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= PAGE_W'(RST_START);
      stop_q  <= PAGE_W'(RST_STOP);
      bnd_q   <= PAGE_W'(RST_START);
      cur_q   <= PAGE_W'(RST_START);
    end else begin
      start_q <= start_d;
      stop_q  <= stop_d;
      bnd_q   <= bnd_d;
      cur_q   <= cur_d;
    end
  end

  assign start_pg = start_q;
  assign stop_pg  = stop_q;
  assign bnd_pg   = bnd_q;
  assign cur_pg   = cur_q;

  // R2: window registers frozen across consecutive running cycles
  p_win_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run)) |-> ($stable(start_q) && $stable(stop_q)));

  // R5: the current page moves while running only after a commit
  p_cur_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(run) && !$past(commit)) |-> $stable(cur_q));
endmodule

// File: rtl/rxr_wr_ctrl.sv
module rxr_wr_ctrl
  import rxr_pkg::*;
#(
  parameter int PAGE_W = 8,
  parameter int OFF_W  = 8,
  parameter int DATA_W = 8,
  localparam int ADDR_W = PAGE_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              rx_valid,
  input  logic              rx_sof,
  input  logic              rx_eof,
  input  logic              rx_err,
  input  logic [DATA_W-1:0] rx_data,
  input  logic [PAGE_W-1:0] start_pg,
  input  logic [PAGE_W-1:0] stop_pg,
  input  logic [PAGE_W-1:0] bnd_pg,
  input  logic [PAGE_W-1:0] cur_pg,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              commit,
  output logic [PAGE_W-1:0] commit_page,
  output logic              frame_ok,
  output logic              frame_bad,
  output logic              ring_ovf
);
  rx_state_e         state_q, state_d;
  logic [ADDR_W-1:0] wptr_q, wptr_d;
  logic              ok_q, ok_d, bad_q, bad_d, ovf_q, ovf_d;
  logic              take, last_in_page, need_next, ovf_hit;
  logic [ADDR_W-1:0] wr_addr;
  logic [PAGE_W-1:0] np;

  always_comb begin
    take         = run && rx_valid && (rx_sof || state_q == ST_RECV);
    wr_addr      = rx_sof ? {cur_pg, {OFF_W{1'b0}}} : wptr_q;
    last_in_page = &wr_addr[OFF_W-1:0];
  end

  rxr_page_step #(.PAGE_W(PAGE_W)) u_step (
    .page     (wr_addr[ADDR_W-1:OFF_W]),
    .start_pg (start_pg),
    .stop_pg  (stop_pg),
    .next_pg  (np)
  );

  always_comb begin
    need_next = take && (rx_eof || last_in_page);
    ovf_hit   = need_next && (np == bnd_pg) && !(rx_eof && rx_err);
    state_d   = state_q;
    wptr_d    = wptr_q;
    ok_d      = 1'b0;
    bad_d     = 1'b0;
    ovf_d     = 1'b0;
    commit    = 1'b0;
    if (!run) begin
      state_d = ST_IDLE;
    end else if (take) begin
      wptr_d = last_in_page ? {np, {OFF_W{1'b0}}} : wr_addr + 1'b1;
      if (rx_eof) begin
        state_d = ST_IDLE;
        if (rx_err) begin
          bad_d = 1'b1;
        end else if (ovf_hit) begin
          bad_d = 1'b1;
          ovf_d = 1'b1;
        end else begin
          ok_d   = 1'b1;
          commit = 1'b1;
        end
      end else if (ovf_hit) begin
        state_d = ST_DROP;
        bad_d   = 1'b1;
        ovf_d   = 1'b1;
      end else begin
        state_d = ST_RECV;
      end
    end else if (state_q == ST_DROP && rx_valid && rx_eof) begin
      state_d = ST_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      wptr_q  <= '0;
      ok_q    <= 1'b0;
      bad_q   <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      ok_q    <= ok_d;
      bad_q   <= bad_d;
      ovf_q   <= ovf_d;
      if (take) wptr_q <= wptr_d;
    end
  end

  assign mem_we      = take;
  assign mem_addr    = wr_addr;
  assign mem_wdata   = rx_data;
  assign commit_page = np;
  assign frame_ok    = ok_q;
  assign frame_bad   = bad_q;
  assign ring_ovf    = ovf_q;

  // R7: an overflow is always reported as a dropped frame
  p_ovf_is_bad_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ring_ovf |-> frame_bad);

  // R5: a frame is never both committed and dropped
  p_ok_bad_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_ok && frame_bad));

  // R8: nothing reaches the memory while stopped
  p_no_write_stopped_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !mem_we);

  // R3: consecutive bytes inside a page use consecutive addresses
  p_seq_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && !rx_sof && $past(mem_we) && !$past(rx_eof) && $past(run)
     && ($past(mem_addr[OFF_W-1:0]) != {OFF_W{1'b1}}))
    |-> (mem_addr == $past(mem_addr) + 1'b1));
endmodule

// File: rtl/rx_ring_ctrl.sv
module rx_ring_ctrl #(
  parameter int          PAGE_W    = 8,
  parameter int          OFF_W     = 8,
  parameter int          DATA_W    = 8,
  parameter logic [7:0]  RST_START = 8'h40,
  parameter logic [7:0]  RST_STOP  = 8'h80,
  localparam int         ADDR_W    = PAGE_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [PAGE_W-1:0] cfg_wdata,
  input  logic              rx_valid,
  input  logic              rx_sof,
  input  logic              rx_eof,
  input  logic              rx_err,
  input  logic [DATA_W-1:0] rx_data,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [PAGE_W-1:0] ring_start,
  output logic [PAGE_W-1:0] ring_stop,
  output logic [PAGE_W-1:0] cur_page,
  output logic [PAGE_W-1:0] bnd_page,
  output logic              frame_ok,
  output logic              frame_bad,
  output logic              ring_ovf
);
  logic              commit;
  logic [PAGE_W-1:0] commit_page;

  rxr_cfg_regs #(
    .PAGE_W    (PAGE_W),
    .RST_START (RST_START),
    .RST_STOP  (RST_STOP)
  ) u_cfg (
    .clk         (clk),
    .rst_n       (rst_n),
    .run         (run),
    .cfg_we      (cfg_we),
    .cfg_sel     (cfg_sel),
    .cfg_wdata   (cfg_wdata),
    .commit      (commit),
    .commit_page (commit_page),
    .start_pg    (ring_start),
    .stop_pg     (ring_stop),
    .bnd_pg      (bnd_page),
    .cur_pg      (cur_page)
  );

  rxr_wr_ctrl #(
    .PAGE_W (PAGE_W),
    .OFF_W  (OFF_W),
    .DATA_W (DATA_W)
  ) u_wr (
    .clk         (clk),
    .rst_n       (rst_n),
    .run         (run),
    .rx_valid    (rx_valid),
    .rx_sof      (rx_sof),
    .rx_eof      (rx_eof),
    .rx_err      (rx_err),
    .rx_data     (rx_data),
    .start_pg    (ring_start),
    .stop_pg     (ring_stop),
    .bnd_pg      (bnd_page),
    .cur_pg      (cur_page),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .commit      (commit),
    .commit_page (commit_page),
    .frame_ok    (frame_ok),
    .frame_bad   (frame_bad),
    .ring_ovf    (ring_ovf)
  );

  // R6: a committed frame never coincides with a dropped one or an overflow
  p_ok_excl_ovf_r6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ok |-> !ring_ovf);
endmodule

// File: tb/rx_ring_ctrl_tb.sv
`timescale 1ns/1ps
module rx_ring_ctrl_tb;
  logic        clk, rst_n, run, cfg_we;
  logic [1:0]  cfg_sel;
  logic [7:0]  cfg_wdata, rx_data;
  logic        rx_valid, rx_sof, rx_eof, rx_err;
  logic        mem_we;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata, ring_start, ring_stop, cur_page, bnd_page;
  logic        frame_ok, frame_bad, ring_ovf;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  rx_ring_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .run(run), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .rx_valid(rx_valid), .rx_sof(rx_sof),
    .rx_eof(rx_eof), .rx_err(rx_err), .rx_data(rx_data), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .ring_start(ring_start),
    .ring_stop(ring_stop), .cur_page(cur_page), .bnd_page(bnd_page),
    .frame_ok(frame_ok), .frame_bad(frame_bad), .ring_ovf(ring_ovf)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  typedef struct packed {
    logic        sof;
    logic        eof;
    logic        valid;
    logic [7:0]  data;
    logic        exp_we;
    logic [15:0] exp_addr;
  } vec_t;

  // window 0x10..0x12, current 0x10, boundary 0x10
  localparam vec_t VECS [8] = '{
    '{1'b0, 1'b0, 1'b1, 8'h11, 1'b0, 16'h0000},  // stray byte: R8
    '{1'b1, 1'b0, 1'b1, 8'hA1, 1'b1, 16'h1000},  // R3
    '{1'b0, 1'b0, 1'b1, 8'hA2, 1'b1, 16'h1001},
    '{1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 16'h0000},  // gap
    '{1'b0, 1'b1, 1'b1, 8'hA3, 1'b1, 16'h1002},
    '{1'b0, 1'b0, 1'b1, 8'h55, 1'b0, 16'h0000},  // R8 after end
    '{1'b1, 1'b0, 1'b1, 8'hB1, 1'b1, 16'h1100},  // R5 next frame page
    '{1'b0, 1'b1, 1'b1, 8'hB2, 1'b1, 16'h1101}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input logic r, input logic s, input logic e, input logic er,
                     input logic v, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b0; run = r; rx_sof = s; rx_eof = e; rx_err = er; rx_valid = v; rx_data = d;
    #1;
  endtask

  task automatic cfg(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; rx_err = 1'b0;
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    #1;
  endtask

  task automatic idle(input logic r);
    cyc(r, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; run = 1'b0; cfg_we = 1'b0; cfg_sel = 2'd0; cfg_wdata = 8'h00;
    rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; rx_err = 1'b0; rx_data = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(1'b0);
    // R1 reset state
    chk("R1 start", ring_start, 8'h40);
    chk("R1 stop",  ring_stop,  8'h80);
    chk("R1 cur",   cur_page,   8'h40);
    chk("R1 bnd",   bnd_page,   8'h40);
    chk("R1 pulses", {mem_we, frame_ok, frame_bad, ring_ovf}, 4'b0000);

    // R2 configuration while stopped
    cfg(2'd0, 8'h10); cfg(2'd1, 8'h13); cfg(2'd3, 8'h10); cfg(2'd2, 8'h10);
    chk("R2 start set", ring_start, 8'h10);
    chk("R2 stop set",  ring_stop,  8'h13);
    chk("R2 cur set",   cur_page,   8'h10);
    chk("R2 bnd set",   bnd_page,   8'h10);

    // R8 no write while stopped
    cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 8'h77);
    chk("R8 stopped no write", mem_we, 1'b0);

    // table walk (R3, R5, R8)
    for (int i = 0; i < 8; i++) begin
      cyc(1'b1, VECS[i].sof, VECS[i].eof, 1'b0, VECS[i].valid, VECS[i].data);
      chk("R3 table we", mem_we, VECS[i].exp_we);
      if (VECS[i].exp_we) begin
        chk("R3 table addr", mem_addr, VECS[i].exp_addr);
        chk("R3 table data", mem_wdata, VECS[i].data);
      end
      if (i == 5) chk("R5 ok pulse", frame_ok, 1'b1);
    end
    idle(1'b1);
    chk("R5 ok second frame", frame_ok, 1'b1);
    chk("R5 cur after two frames", cur_page, 8'h12);

    // R2 window writes ignored while running, boundary accepted
    @(negedge clk); cfg_we = 1'b1; cfg_sel = 2'd0; cfg_wdata = 8'h55;
    @(negedge clk); cfg_sel = 2'd1; cfg_wdata = 8'h66;
    @(negedge clk); cfg_sel = 2'd3; cfg_wdata = 8'h77;
    @(negedge clk); cfg_sel = 2'd2; cfg_wdata = 8'h12;
    @(negedge clk); cfg_we = 1'b0; #1;
    chk("R2 start frozen", ring_start, 8'h10);
    chk("R2 stop frozen",  ring_stop,  8'h13);
    chk("R2 cur frozen",   cur_page,   8'h12);
    chk("R2 bnd while running", bnd_page, 8'h12);

    // R4 frame straddling the wrap: 0x1200..0x12FF, 0x1000, 0x1001
    for (int i = 0; i < 258; i++) begin
      cyc(1'b1, i == 0, i == 257, 1'b0, 1'b1, 8'(i));
      if (i < 256) chk("R4 addr before wrap", mem_addr, 16'h1200 + 16'(i));
      else         chk("R4 addr after wrap", mem_addr, 16'h1000 + 16'(i - 256));
    end
    idle(1'b1);
    chk("R5 ok after wrap", {frame_ok, frame_bad}, 2'b10);
    chk("R5 cur after wrap", cur_page, 8'h11);

    // R7 overflow on page crossing: page 0x11 next is boundary 0x12
    for (int i = 0; i < 256; i++) begin
      cyc(1'b1, i == 0, 1'b0, 1'b0, 1'b1, 8'hC0);
      if (i == 255) chk("R7 last byte written", {mem_we, mem_addr}, {1'b1, 16'h11FF});
    end
    cyc(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'hC1);
    chk("R7 ovf pulse", {ring_ovf, frame_bad, frame_ok}, 3'b110);
    chk("R7 byte after ovf dropped", mem_we, 1'b0);
    cyc(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 8'hC2);
    chk("R7 end byte dropped", mem_we, 1'b0);
    idle(1'b1);
    chk("R7 no pulse at end", {ring_ovf, frame_bad, frame_ok}, 3'b000);
    chk("R7 cur unchanged", cur_page, 8'h11);

    // R7 overflow detected at the end byte
    cyc(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 8'hD0);
    chk("R7 single byte written", mem_addr, 16'h1100);
    idle(1'b1);
    chk("R7 ovf at end", {ring_ovf, frame_bad, frame_ok}, 3'b110);
    chk("R7 cur kept", cur_page, 8'h11);

    // R6 error frame
    cfg(2'd2, 8'h10);
    cyc(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 8'hE0);
    cyc(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 8'hE1);
    idle(1'b1);
    chk("R6 bad only", {ring_ovf, frame_bad, frame_ok}, 3'b010);
    chk("R6 cur kept", cur_page, 8'h11);

    // R9 restart on start marker inside a frame
    cyc(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 8'hF0);
    cyc(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'hF1);
    cyc(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 8'hF2);
    chk("R9 restart addr", mem_addr, 16'h1100);
    cyc(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 8'hF3);
    chk("R9 next addr", mem_addr, 16'h1101);
    idle(1'b1);
    chk("R9 commit", cur_page, 8'h12);

    // R10 run falls mid-frame
    cyc(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 8'h90);
    chk("R10 frame start", mem_addr, 16'h1200);
    cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h91);
    chk("R10 stopped byte", mem_we, 1'b0);
    cyc(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'h92);
    chk("R10 no resume", mem_we, 1'b0);
    cyc(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 8'h93);
    chk("R10 end ignored", mem_we, 1'b0);
    idle(1'b1);
    chk("R10 no pulse", {ring_ovf, frame_bad, frame_ok}, 3'b000);
    chk("R10 cur kept", cur_page, 8'h12);

    finish_run();
  end
endmodule